// File: doc/BRIEF.md
# Interval Timer Count Capture and Read Path

This block is the read side of a bank of three 16-bit down-counters in an interval timer, together with the small counting element each counter needs. Software reaches it through an 8-bit register port. A 2-bit address selects one of the three counters or the control word register. Read and write strobes last one cycle each. Each counter advances on its own tick, which acts as a clock enable. Counters 0 and 1 always count when ticked. Counter 2 counts only while an external gate enable is high.

Each counter has an output latch that follows its counting element until a capture command freezes it. The latch stays frozen until software has read the whole value, or until the counter is reprogrammed. A read-back command captures the count, a status byte, or both, for any subset of counters in one write. Every counter access is byte-sequenced according to the counter's programmed access format. Reads and writes keep separate byte pointers, so the two directions can interleave on the same counter.

Top module: `tmr_readback_top`

## Requirements
- R1: Addresses 0, 1 and 2 select counters 0, 1 and 2, and address 3 is the control word register. A read of address 3 returns 0x00. After reset, rdata and out_flag are zero.
- R2: Control word bits 7:6 select the counter (0–2) and bits 5:4 select the access format: 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits 3:1 hold the mode and bit 0 holds the BCD flag. A low-only write clears the high byte, and a high-only write clears the low byte. Single-byte formats return the same byte on every read.
- R3: A control word with bits 5:4 = 00 captures the selected counter's count into its output latch. Counting continues while the latch is held.
- R4: A capture command issued while that counter's latch already holds an unread value is ignored.
- R5: The latch returns to following the counter once the full value has been read, as one byte or two depending on the format. Reprogramming the counter also releases it.
- R6: Accesses to other counters between the two bytes of a two-byte read do not disturb that read's byte order.
- R7: In two-byte format the read and write byte pointers of one counter are independent. The sequence read low, write low, read high, write high returns the old value and loads the new one.
- R8: A control word with bits 7:6 = 11 is a read-back command. Bit 5 low captures the count, bit 4 low captures the status, and bits 1, 2 and 3 select counters 0, 1 and 2. The status byte is {OUT, null-count, format[1:0], mode[2:0], BCD}, most significant bit first.
- R9: When both status and count are captured, the first read returns the status byte and the following reads return the count in the programmed format.
- R10: Programming a counter, or completing a count write, sets its null-count flag. The next enabled tick loads the new count into the counter and clears the flag.
- R11: Counter 2 holds its count while its gate enable is low, so a direct read returns a stable value. Counters 0 and 1 count on every tick.
- R12: out_flag of a counter is cleared by programming and by a count load. It is set when an enabled tick takes the count from 1 to 0.
- R13: rdata is registered. It takes the addressed byte in the cycle after a read strobe and is unchanged in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: counters 0–2, control word at 3 |
| rd | input | 1 | Read strobe, one cycle per byte |
| wr | input | 1 | Write strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tick | input | 3 | Per-counter count enable |
| gate2_en | input | 1 | Gate enable of counter 2 |
| out_flag | output | 3 | Per-counter terminal-count flag |

## Verification
The hardest state to reach from the ports is a held latch that receives a second capture while counting continues, mixed with interleaved write bytes and accesses to other counters before the high byte is read. A directed sequence stops all ticks, loads known counts, captures a value, ticks a set number of times, and issues a second capture, so the expected bytes can be worked out by hand. A randomized phase then mixes read-back masks, captures, reprogramming, gate changes and ticks, and compares rdata and out_flag against a behavioural model on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    FMT_CAPTURE = 2'b00,
    FMT_LO      = 2'b01,
    FMT_HI      = 2'b10,
    FMT_WORD    = 2'b11
  } fmt_e;

  localparam logic [1:0] SEL_READBACK = 2'b11;
  localparam int         STATUS_W     = 8;
  localparam int         MODE_W       = 3;
endpackage

// File: rtl/tmr_count_elem.sv
module tmr_count_elem
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              gate,
  input  logic              prog_stb,
  input  fmt_e              prog_fmt,
  input  logic [MODE_W-1:0] prog_mode,
  input  logic              prog_bcd,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  ce,
  output logic              null_cnt,
  output logic              load_pend,
  output logic              out_flag,
  output fmt_e              fmt,
  output logic [MODE_W-1:0] mode,
  output logic              bcd
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cr;
  logic             wr_hi_next;
  logic             step;
  logic             wr_done;

  assign step    = tick && gate;
  assign wr_done = wr_stb && !prog_stb && (fmt != FMT_WORD || wr_hi_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce <= '0;
    end else if (step) begin
      if (load_pend) ce <= cr;
      else           ce <= ce - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_flag <= 1'b0;
    end else if (prog_stb) begin
      out_flag <= 1'b0;
    end else if (step) begin
      if (load_pend)      out_flag <= 1'b0;
      else if (ce == ONE) out_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      null_cnt  <= 1'b0;
      load_pend <= 1'b0;
    end else if (prog_stb) begin
      null_cnt  <= 1'b1;
      load_pend <= 1'b0;
    end else if (wr_done) begin
      null_cnt  <= 1'b1;
      load_pend <= 1'b1;
    end else if (step && load_pend) begin
      null_cnt  <= 1'b0;
      load_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt        <= FMT_WORD;
      mode       <= '0;
      bcd        <= 1'b0;
      cr         <= '0;
      wr_hi_next <= 1'b0;
    end else if (prog_stb) begin
      fmt        <= prog_fmt;
      mode       <= prog_mode;
      bcd        <= prog_bcd;
      wr_hi_next <= 1'b0;
    end else if (wr_stb) begin
      unique case (fmt)
        FMT_LO: cr <= {{DATA_W{1'b0}}, wdata};
        FMT_HI: cr <= {wdata, {DATA_W{1'b0}}};
        default: begin
          if (wr_hi_next) cr[CNT_W-1:DATA_W] <= wdata;
          else            cr[DATA_W-1:0]     <= wdata;
          wr_hi_next <= !wr_hi_next;
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_read_path.sv
module tmr_read_path
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    ce,
  input  fmt_e                fmt,
  input  logic [STATUS_W-1:0] status_in,
  input  logic                prog_stb,
  input  logic                cnt_cap_stb,
  input  logic                st_cap_stb,
  input  logic                rd_stb,
  output logic [DATA_W-1:0]   rd_byte,
  output logic [CNT_W-1:0]    ol_val,
  output logic                ol_held
);
  logic [STATUS_W-1:0] st_q;
  logic                st_held;
  logic                rd_hi_next;
  logic [CNT_W-1:0]    view;
  logic                pick_hi;
  logic                last_byte;

  assign view      = ol_held ? ol_val : ce;
  assign pick_hi   = (fmt == FMT_HI) || (fmt == FMT_WORD && rd_hi_next);
  assign last_byte = (fmt != FMT_WORD) || rd_hi_next;

  always_comb begin
    if (st_held)      rd_byte = st_q[DATA_W-1:0];
    else if (pick_hi) rd_byte = view[CNT_W-1:DATA_W];
    else              rd_byte = view[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ol_val     <= '0;
      ol_held    <= 1'b0;
      st_q       <= '0;
      st_held    <= 1'b0;
      rd_hi_next <= 1'b0;
    end else if (prog_stb) begin
      ol_held    <= 1'b0;
      st_held    <= 1'b0;
      rd_hi_next <= 1'b0;
    end else begin
      if (cnt_cap_stb && !ol_held) begin
        ol_val  <= ce;
        ol_held <= 1'b1;
      end
      if (st_cap_stb && !st_held) begin
        st_q    <= status_in;
        st_held <= 1'b1;
      end
      if (rd_stb) begin
        if (st_held) begin
          st_held <= 1'b0;
        end else begin
          if (fmt == FMT_WORD) rd_hi_next <= !rd_hi_next;
          if (last_byte)       ol_held    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_readback_top.sv
module tmr_readback_top
  import tmr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_CNT   = 3,
  parameter int ADDR_W    = 2,
  parameter int GATED_IDX = 2,
  localparam int CNT_W    = 2 * DATA_W,
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_CNT-1:0] tick,
  input  logic               gate2_en,
  output logic [NUM_CNT-1:0] out_flag
);
  logic              ctrl_wr;
  logic [1:0]        cw_sel;
  fmt_e              cw_fmt;
  logic              is_rb;

  logic [CNT_W-1:0]  ce_arr     [NUM_CNT];
  logic [CNT_W-1:0]  ol_arr     [NUM_CNT];
  logic [DATA_W-1:0] byte_arr   [NUM_CNT];
  logic [NUM_CNT-1:0] ol_held_v;
  logic [NUM_CNT-1:0] null_v;
  logic [NUM_CNT-1:0] pend_v;
  logic [NUM_CNT-1:0] rd_hit_v;

  assign ctrl_wr = wr && (addr == CTRL_ADDR);
  assign cw_sel  = wdata[7:6];
  assign cw_fmt  = fmt_e'(wdata[5:4]);
  assign is_rb   = (cw_sel == SEL_READBACK);

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_ch
    logic              sel_me;
    logic              prog_stb;
    logic              cnt_cap;
    logic              st_cap;
    logic              gate;
    fmt_e              fmt;
    logic [MODE_W-1:0] mode;
    logic              bcd;
    logic [STATUS_W-1:0] status;

    assign sel_me   = !is_rb && (cw_sel == 2'(gi));
    assign prog_stb = ctrl_wr && sel_me && (cw_fmt != FMT_CAPTURE);
    assign cnt_cap  = ctrl_wr && ((sel_me && cw_fmt == FMT_CAPTURE) ||
                                  (is_rb && !wdata[5] && wdata[gi+1]));
    assign st_cap   = ctrl_wr && is_rb && !wdata[4] && wdata[gi+1];
    assign rd_hit_v[gi] = rd && (addr == ADDR_W'(gi));

    if (gi == GATED_IDX) begin : g_gated
      assign gate = gate2_en;
    end else begin : g_free
      assign gate = 1'b1;
    end

    assign status = {out_flag[gi], null_v[gi], fmt, mode, bcd};

    tmr_count_elem #(.DATA_W(DATA_W)) u_ce (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick[gi]),
      .gate      (gate),
      .prog_stb  (prog_stb),
      .prog_fmt  (cw_fmt),
      .prog_mode (wdata[3:1]),
      .prog_bcd  (wdata[0]),
      .wr_stb    (wr && (addr == ADDR_W'(gi))),
      .wdata     (wdata),
      .ce        (ce_arr[gi]),
      .null_cnt  (null_v[gi]),
      .load_pend (pend_v[gi]),
      .out_flag  (out_flag[gi]),
      .fmt       (fmt),
      .mode      (mode),
      .bcd       (bcd)
    );

    tmr_read_path #(.DATA_W(DATA_W)) u_rp (
      .clk         (clk),
      .rst         (rst),
      .ce          (ce_arr[gi]),
      .fmt         (fmt),
      .status_in   (status),
      .prog_stb    (prog_stb),
      .cnt_cap_stb (cnt_cap),
      .st_cap_stb  (st_cap),
      .rd_stb      (rd_hit_v[gi]),
      .rd_byte     (byte_arr[gi]),
      .ol_val      (ol_arr[gi]),
      .ol_held     (ol_held_v[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (addr >= CTRL_ADDR) rdata <= '0;
      else                   rdata <= byte_arr[addr];
    end
  end
endmodule

// File: rtl/tmr_readback_chk.sv
module tmr_readback_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd,
  input logic              ctrl_wr,
  input logic [2:0]        tick,
  input logic              gate2_en,
  input logic [DATA_W-1:0] rdata,
  input logic [CNT_W-1:0]  ce0,
  input logic [CNT_W-1:0]  ce2,
  input logic              pend0,
  input logic              null0,
  input logic              held1,
  input logic [CNT_W-1:0]  olv1,
  input logic              rd_hit1
);
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));

  p_gate_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    !(gate2_en && tick[2]) |=> $stable(ce2));

  p_free_count_r3: assert property (@(posedge clk) disable iff (rst)
    (tick[0] && !pend0) |=> (ce0 == $past(ce0) - 1'b1));

  p_null_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(null0) |-> $past(tick[0]));

  p_capture_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (held1 && !rd_hit1 && !ctrl_wr) |=> (held1 && $stable(olv1)));
endmodule

bind tmr_readback_top tmr_readback_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd       (rd),
  .ctrl_wr  (ctrl_wr),
  .tick     (tick[2:0]),
  .gate2_en (gate2_en),
  .rdata    (rdata),
  .ce0      (ce_arr[0]),
  .ce2      (ce_arr[2]),
  .pend0    (pend_v[0]),
  .null0    (null_v[0]),
  .held1    (ol_held_v[1]),
  .olv1     (ol_arr[1]),
  .rd_hit1  (rd_hit_v[1])
);

// File: tb/tmr_readback_top_tb.sv
module tmr_readback_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] tick = '0;
  logic       gate2_en = 1'b1;
  logic [2:0] out_flag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_readback_top u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .gate2_en(gate2_en), .out_flag(out_flag)
  );

  // behavioural reference model
  logic [15:0] m_ce [3];
  logic [15:0] m_cr [3];
  logic [15:0] m_ol [3];
  logic [7:0]  m_st [3];
  logic [1:0]  m_fmt [3];
  logic [2:0]  m_mode [3];
  logic [2:0]  m_bcd, m_pend, m_null, m_out, m_olh, m_sth, m_rp, m_wp;
  logic [7:0]  m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_ce[i] = '0; m_cr[i] = '0; m_ol[i] = '0; m_st[i] = '0;
        m_fmt[i] = 2'b11; m_mode[i] = '0;
      end
      m_bcd = '0; m_pend = '0; m_null = '0; m_out = '0;
      m_olh = '0; m_sth = '0; m_rp = '0; m_wp = '0; m_rdata = '0;
    end else begin
      logic [15:0] oce [3];
      logic [2:0]  oout, onull;
      for (int i = 0; i < 3; i++) oce[i] = m_ce[i];
      oout = m_out; onull = m_null;
      if (rd) begin
        if (addr == 2'd3) m_rdata = 8'h00;
        else begin
          int i;
          logic [15:0] v;
          i = int'(addr);
          if (m_sth[i]) begin
            m_rdata = m_st[i]; m_sth[i] = 1'b0;
          end else begin
            v = m_olh[i] ? m_ol[i] : m_ce[i];
            if (m_fmt[i] == 2'b10 || (m_fmt[i] == 2'b11 && m_rp[i])) m_rdata = v[15:8];
            else m_rdata = v[7:0];
            if (m_fmt[i] == 2'b11) begin
              if (m_rp[i]) m_olh[i] = 1'b0;
              m_rp[i] = !m_rp[i];
            end else m_olh[i] = 1'b0;
          end
        end
      end
      for (int i = 0; i < 3; i++) begin
        if (tick[i] && (i != 2 || gate2_en)) begin
          if (m_pend[i]) begin
            m_ce[i] = m_cr[i]; m_out[i] = 1'b0; m_pend[i] = 1'b0; m_null[i] = 1'b0;
          end else begin
            if (m_ce[i] == 16'd1) m_out[i] = 1'b1;
            m_ce[i] = m_ce[i] - 16'd1;
          end
        end
      end
      if (wr) begin
        if (addr == 2'd3) begin
          if (wdata[7:6] == 2'b11) begin
            for (int i = 0; i < 3; i++) begin
              if (wdata[i+1]) begin
                if (!wdata[5] && !m_olh[i]) begin m_ol[i] = oce[i]; m_olh[i] = 1'b1; end
                if (!wdata[4] && !m_sth[i]) begin
                  m_st[i] = {oout[i], onull[i], m_fmt[i], m_mode[i], m_bcd[i]};
                  m_sth[i] = 1'b1;
                end
              end
            end
          end else begin
            int i;
            i = int'(wdata[7:6]);
            if (wdata[5:4] == 2'b00) begin
              if (!m_olh[i]) begin m_ol[i] = oce[i]; m_olh[i] = 1'b1; end
            end else begin
              m_fmt[i] = wdata[5:4]; m_mode[i] = wdata[3:1]; m_bcd[i] = wdata[0];
              m_olh[i] = 1'b0; m_sth[i] = 1'b0; m_rp[i] = 1'b0; m_wp[i] = 1'b0;
              m_null[i] = 1'b1; m_pend[i] = 1'b0; m_out[i] = 1'b0;
            end
          end
        end else begin
          int i;
          logic done;
          i = int'(addr);
          done = 1'b1;
          case (m_fmt[i])
            2'b01: m_cr[i] = {8'h00, wdata};
            2'b10: m_cr[i] = {wdata, 8'h00};
            default: begin
              if (m_wp[i]) m_cr[i][15:8] = wdata;
              else begin m_cr[i][7:0] = wdata; done = 1'b0; end
              m_wp[i] = !m_wp[i];
            end
          endcase
          if (done) begin m_null[i] = 1'b1; m_pend[i] = 1'b1; end
        end
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(rdata == m_rdata, "R13 rdata vs model", rdata, m_rdata);
      check(out_flag == m_out, "R12 out_flag vs model", out_flag, m_out);
    end
  end

  task automatic wr_b(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic ticks(input logic [2:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      tick = m;
      @(negedge clk);
    end
    tick = '0;
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdata == 8'h00, "R1 reset rdata", rdata, 0);
    check(out_flag == 3'b000, "R1 reset out_flag", out_flag, 0);

    // R8/R10: program counter 0, word format, mode 2
    wr_b(2'd3, 8'h34);
    wr_b(2'd3, 8'hE2);
    rd_chk(2'd0, 8'h74, "R8 status after program");
    wr_b(2'd0, 8'h34);
    wr_b(2'd0, 8'h12);
    wr_b(2'd3, 8'hE2);
    rd_chk(2'd0, 8'h74, "R10 null set after count write");
    ticks(3'b001, 1);
    wr_b(2'd3, 8'hE2);
    rd_chk(2'd0, 8'h34, "R10 null cleared by load tick");

    // R3/R4/R5: capture, count on, second capture ignored
    wr_b(2'd3, 8'h00);
    ticks(3'b001, 5);
    wr_b(2'd3, 8'h00);
    rd_chk(2'd0, 8'h34, "R4 second capture ignored low byte");
    rd_chk(2'd0, 8'h12, "R3 captured high byte");
    rd_chk(2'd0, 8'h2F, "R5 follows counter low byte");
    rd_chk(2'd0, 8'h12, "R5 follows counter high byte");

    // R6: other-counter traffic between bytes
    wr_b(2'd3, 8'h74);
    wr_b(2'd1, 8'h00);
    wr_b(2'd1, 8'h01);
    ticks(3'b010, 1);
    wr_b(2'd3, 8'h40);
    rd_chk(2'd1, 8'h00, "R6 low byte");
    wr_b(2'd0, 8'h99);
    rd_chk(2'd0, 8'h2F, "R6 other counter read");
    rd_chk(2'd1, 8'h01, "R6 high byte after other traffic");
    wr_b(2'd0, 8'h00);

    // R7: interleaved read and write of counter 1
    wr_b(2'd3, 8'h40);
    rd_chk(2'd1, 8'h00, "R7 read low");
    wr_b(2'd1, 8'hAA);
    rd_chk(2'd1, 8'h01, "R7 read high after write low");
    wr_b(2'd1, 8'hBB);
    ticks(3'b010, 1);
    rd_chk(2'd1, 8'hAA, "R7 new low byte");
    rd_chk(2'd1, 8'hBB, "R7 new high byte");

    // R2: single-byte formats on counter 2
    gate2_en = 1'b1;
    wr_b(2'd3, 8'h90);
    wr_b(2'd2, 8'h55);
    ticks(3'b100, 1);
    rd_chk(2'd2, 8'h55, "R2 low-only read");
    rd_chk(2'd2, 8'h55, "R2 low-only repeat read");
    wr_b(2'd3, 8'hA0);
    wr_b(2'd2, 8'h77);
    ticks(3'b100, 1);
    rd_chk(2'd2, 8'h77, "R2 high-only read");

    // R11: gate hold
    wr_b(2'd3, 8'h90);
    wr_b(2'd2, 8'h10);
    ticks(3'b100, 1);
    gate2_en = 1'b0;
    ticks(3'b100, 3);
    rd_chk(2'd2, 8'h10, "R11 gate low holds count");
    gate2_en = 1'b1;
    ticks(3'b100, 3);
    rd_chk(2'd2, 8'h0D, "R11 gate high counts");

    // R12: terminal count
    ticks(3'b100, 12);
    check(out_flag[2] == 1'b0, "R12 out low at one", out_flag[2], 0);
    ticks(3'b100, 1);
    check(out_flag[2] == 1'b1, "R12 out set at zero", out_flag[2], 1);
    wr_b(2'd3, 8'h90);
    check(out_flag[2] == 1'b0, "R12 out cleared by program", out_flag[2], 0);

    // R9: status then count
    wr_b(2'd3, 8'h34);
    wr_b(2'd0, 8'h05);
    wr_b(2'd0, 8'h00);
    ticks(3'b001, 1);
    wr_b(2'd3, 8'hC2);
    rd_chk(2'd0, 8'h34, "R9 status first");
    rd_chk(2'd0, 8'h05, "R9 count low");
    rd_chk(2'd0, 8'h00, "R9 count high");

    rd_chk(2'd3, 8'h00, "R1 control address reads zero");

    // randomized phase against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 5);
      tick = 3'($urandom);
      gate2_en = 1'($urandom);
      addr = 2'($urandom);
      wdata = 8'($urandom);
      rd = (op == 1 || op == 2);
      wr = (op == 3 || op == 4 || op == 5);
      @(negedge clk);
      rd = 1'b0; wr = 1'b0; tick = '0;
    end
    @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule